// File: doc/BRIEF.md
# Dual-Tone Alert Guard-Time Qualifier

This block turns a raw, noisy "both alert tones present" flag into a time-qualified steering output. A saturating up/down integrator, advanced only on a one-millisecond tick, moves toward a present threshold while the raw flag is high and back toward zero while it is low. When the present threshold is crossed the active-low steering output falls; it rises again only after the integrator, reloaded with the absent guard value, has been drained by low ticks. Present and absent guard times are programmed separately, so attack and release can be asymmetric; an absent guard near 15 ticks is a typical setting.

A second stage watches each qualified pulse. It measures how many ticks the steering output stayed low, tracks the longest closed dropout (a run of low raw ticks followed by a return of the tone) inside the pulse, and on release emits a one-cycle valid strobe only when the length lies within the programmed limits and no dropout exceeded the programmed span. Firmware uses the steering edge for fast reaction and the strobe to reject speech that mimics the alert.

The enable input covers both the "not in alert-detection mode" and "powered down" cases: while it is low all state is cleared.

Top module: `tone_alert_qualifier`

## Requirements
- R1: While reset is asserted or enable_i is low, std_no is 1, guard_o is 0 and valid_o is 0 from the next clock edge on, and the integrator and pulse measurements restart from zero.
- R2: From a cleared state, std_no falls (guard_o rises) at the clock edge of the Nth consecutive tick that sees tone_est_i high, N = present_guard_i (a value of 0 behaves as 1).
- R3: While not qualified, each tick with tone_est_i low lowers the integrator by one (not below zero) and each tick with it high raises it by one, so an interrupted tone needs its lost ticks made up before qualification.
- R4: On qualification the integrator is loaded with the absent guard A = absent_guard_i (0 behaves as 1); each later low tick lowers it, each high tick raises it up to A, and std_no rises at the edge of the tick that takes it from 1 to 0, i.e. after A consecutive low ticks from a full integrator.
- R5: While qualified, ticks with the tone high never release the output and never start a new qualification; std_no stays 0 until the release of R4.
- R6: Only clock cycles with tick_ms_i high change the state; changes of tone_est_i between ticks have no effect on any output.
- R7: valid_o pulses for exactly one cycle, at the same edge where std_no rises, when the pulse length D (the number of ticks seen while guard_o was already 1, including the releasing tick) satisfies min_len_i <= D <= max_len_i and R9 found no long dropout.
- R8: A pulse whose length D exceeds max_len_i produces no strobe (an all-ones max_len_i means no upper bound).
- R9: A dropout is a run of low ticks inside a qualified pulse that ends with a high tick; if any such run is longer than max_gap_i ticks the pulse produces no strobe. The final low run that causes the release is not a dropout.
- R10: Dropping enable_i in the middle of a qualified pulse releases std_no at the next edge without a strobe, and after re-enabling, a full present guard is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Alert detection active; low clears all state |
| tick_ms_i | input | 1 | One-cycle timing tick, nominally every millisecond |
| tone_est_i | input | 1 | Raw dual-tone early-steering flag, active high |
| present_guard_i | input | GW | Present guard time in ticks |
| absent_guard_i | input | GW | Absent guard time in ticks |
| min_len_i | input | DW | Minimum valid pulse length in ticks |
| max_len_i | input | DW | Maximum valid pulse length in ticks |
| max_gap_i | input | DW | Longest allowed dropout in ticks |
| guard_o | output | 1 | Qualified guard state, active high |
| std_no | output | 1 | Delayed steering output, active low |
| valid_o | output | 1 | One-cycle valid-alert strobe |

## Verification
A wrong integrator value shows at the ports as a steering edge one or more ticks early or late, so it surfaces within the present or absent guard window of the affected pulse. A wrong length or dropout measurement stays hidden until the release tick, where it appears as a missing or spurious strobe. The bench therefore compares all three outputs on every cycle against a tick-level model, so any deviation is caught at the first edge where an output differs.

// File: rtl/tdq_pkg.sv
package tdq_pkg;

  // Qualification state of the guard integrator.
  typedef enum logic {
    G_IDLE = 1'b0,
    G_HELD = 1'b1
  } guard_e;

endpackage

// File: rtl/tdq_guard.sv
module tdq_guard
  import tdq_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          tone_i,
  input  logic [GW-1:0] pres_i,
  input  logic [GW-1:0] abs_i,
  output logic          held_o,
  output logic          rel_o
);

  localparam logic [GW-1:0] ONE = GW'(1);

  guard_e        st_q, st_d;
  logic [GW-1:0] cnt_q, cnt_d;
  logic [GW-1:0] pres_eff, abs_eff;
  logic          rel;

  assign pres_eff = (pres_i == '0) ? ONE : pres_i;
  assign abs_eff  = (abs_i  == '0) ? ONE : abs_i;

  // Next-state logic for the tick-driven integrator.
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    rel   = 1'b0;
    if (!en_i) begin
      st_d  = G_IDLE;
      cnt_d = '0;
    end else if (tick_i) begin
      unique case (st_q)
        G_IDLE: begin
          if (tone_i) begin
            if (cnt_q >= pres_eff - ONE) begin
              st_d  = G_HELD;
              cnt_d = abs_eff;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
          end
        end
        G_HELD: begin
          if (!tone_i) begin
            if (cnt_q <= ONE) begin
              st_d  = G_IDLE;
              cnt_d = '0;
              rel   = 1'b1;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end else if (cnt_q >= abs_eff) begin
            cnt_d = abs_eff;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: begin
          st_d  = G_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= G_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign held_o = (st_q == G_HELD);
  assign rel_o  = rel;

  // R1: disable clears the qualified state at the next edge
  a_r1_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !held_o);

  // R6: no tick, no change of state
  a_r6_no_tick_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> ($stable(held_o) && $stable(cnt_q)));

  // R5: tone present while held never releases
  a_r5_held_with_tone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && tone_i && held_o) |=> held_o);

  // R2: qualification only on a tick with tone present
  a_r2_rise_needs_tone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_o && !(en_i && tick_i && tone_i)) |=> !held_o);

  // R4: integrator never exceeds the loaded absent value while held
  a_r4_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && en_i && tick_i && $stable(abs_i)) |=> (cnt_q <= abs_eff));

endmodule

// File: rtl/tdq_pulse_eval.sv
module tdq_pulse_eval #(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          tone_i,
  input  logic          held_i,
  input  logic          rel_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] max_i,
  input  logic [DW-1:0] gap_i,
  output logic          valid_o
);

  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] SATV = '1;

  logic [DW-1:0] dur_q, dur_d, gap_q, gap_d, dur_inc;
  logic          bad_q, bad_d, over_q, over_d, valid_q, valid_d;

  assign dur_inc = (dur_q == SATV) ? SATV : dur_q + ONE;

  // Length, dropout and verdict next-state logic.
  always_comb begin
    dur_d   = dur_q;
    gap_d   = gap_q;
    bad_d   = bad_q;
    over_d  = over_q;
    valid_d = 1'b0;
    if (!en_i) begin
      dur_d  = '0;
      gap_d  = '0;
      bad_d  = 1'b0;
      over_d = 1'b0;
    end else if (tick_i) begin
      if (!held_i) begin
        dur_d  = '0;
        gap_d  = '0;
        bad_d  = 1'b0;
        over_d = 1'b0;
      end else begin
        dur_d  = dur_inc;
        over_d = over_q | (dur_inc > max_i);
        if (tone_i) begin
          if (gap_q > gap_i) begin
            bad_d = 1'b1;
          end
          gap_d = '0;
        end else if (gap_q != SATV) begin
          gap_d = gap_q + ONE;
        end
        if (rel_i) begin
          valid_d = (dur_inc >= min_i) && !over_d && !bad_q;
          dur_d   = '0;
          gap_d   = '0;
          bad_d   = 1'b0;
          over_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dur_q   <= '0;
      gap_q   <= '0;
      bad_q   <= 1'b0;
      over_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      dur_q   <= dur_d;
      gap_q   <= gap_d;
      bad_q   <= bad_d;
      over_q  <= over_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

  // R7: strobe lasts a single cycle
  a_r7_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7: strobe only coincides with the falling guard state
  a_r7_strobe_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!held_i && $past(held_i)));

  // R8: a pulse already over length never yields a strobe
  a_r8_over_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_q && en_i && $stable(max_i)) |=> !valid_o);

  // R9: a recorded long dropout never yields a strobe
  a_r9_gap_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_q |=> !valid_o);

endmodule

// File: rtl/tone_alert_qualifier.sv
module tone_alert_qualifier #(
  parameter int GW = 8,
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          tick_ms_i,
  input  logic          tone_est_i,
  input  logic [GW-1:0] present_guard_i,
  input  logic [GW-1:0] absent_guard_i,
  input  logic [DW-1:0] min_len_i,
  input  logic [DW-1:0] max_len_i,
  input  logic [DW-1:0] max_gap_i,
  output logic          guard_o,
  output logic          std_no,
  output logic          valid_o
);

  logic held, rel;

  tdq_guard #(.GW(GW)) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (enable_i),
    .tick_i (tick_ms_i),
    .tone_i (tone_est_i),
    .pres_i (present_guard_i),
    .abs_i  (absent_guard_i),
    .held_o (held),
    .rel_o  (rel)
  );

  tdq_pulse_eval #(.DW(DW)) u_eval (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enable_i),
    .tick_i  (tick_ms_i),
    .tone_i  (tone_est_i),
    .held_i  (held),
    .rel_i   (rel),
    .min_i   (min_len_i),
    .max_i   (max_len_i),
    .gap_i   (max_gap_i),
    .valid_o (valid_o)
  );

  assign guard_o = held;
  assign std_no  = ~held;

  // R1: disabled block shows idle outputs at the next edge
  a_r1_disabled_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (std_no && !guard_o && !valid_o));

  // R10: leaving the enabled state mid-pulse never strobes
  a_r10_no_strobe_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && guard_o) |=> !valid_o);

endmodule

// File: tb/tone_alert_qualifier_tb.sv
`timescale 1ns/1ps
module tone_alert_qualifier_tb;
  localparam int GW = 8;
  localparam int DW = 12;
  localparam int SAT = (1 << DW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, enable, tick, tone;
  logic guard_o, std_no, valid_o;
  int pg, ag, mn, mx, gp;

  tone_alert_qualifier #(.GW(GW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .tick_ms_i(tick),
    .tone_est_i(tone), .present_guard_i(GW'(pg)), .absent_guard_i(GW'(ag)),
    .min_len_i(DW'(mn)), .max_len_i(DW'(mx)), .max_gap_i(DW'(gp)),
    .guard_o(guard_o), .std_no(std_no), .valid_o(valid_o)
  );

  int n_vec = 0, n_bad = 0, n_strobe = 0;
  string cur_req = "R1";
  bit done = 0;

  // Reference state derived from the requirements
  bit m_held, m_bad, m_over, m_valid;
  int m_cnt, m_dur, m_gap;

  task automatic model_clear();
    m_held = 0; m_cnt = 0; m_dur = 0; m_gap = 0; m_bad = 0; m_over = 0;
  endtask

  task automatic model_step(input bit en, input bit tk, input bit est);
    int pe, ae;
    bit rel;
    pe = (pg == 0) ? 1 : pg;
    ae = (ag == 0) ? 1 : ag;
    rel = 0;
    m_valid = 0;
    if (!en) begin
      model_clear();
    end else if (tk) begin
      if (!m_held) begin
        m_dur = 0; m_gap = 0; m_bad = 0; m_over = 0;
        if (est) begin
          if (m_cnt + 1 >= pe) begin m_held = 1; m_cnt = ae; end
          else m_cnt++;
        end else if (m_cnt > 0) m_cnt--;
      end else begin
        if (m_dur < SAT) m_dur++;
        if (m_dur > mx) m_over = 1;
        if (est) begin
          if (m_gap > gp) m_bad = 1;
          m_gap = 0;
          if (m_cnt < ae) m_cnt++;
        end else begin
          if (m_gap < SAT) m_gap++;
          if (m_cnt <= 1) rel = 1; else m_cnt--;
        end
        if (rel) begin
          m_valid = (m_dur >= mn) && !m_over && !m_bad;
          model_clear();
        end
      end
    end
  endtask

  task automatic check();
    n_vec++;
    if (m_valid) n_strobe++;
    if (std_no !== !m_held || guard_o !== m_held || valid_o !== m_valid) begin
      n_bad++;
      $display("FAIL %s: std_no=%b guard=%b valid=%b expected std_no=%b guard=%b valid=%b",
               cur_req, std_no, guard_o, valid_o, !m_held, m_held, m_valid);
    end
  endtask

  task automatic cyc(input bit en, input bit tk, input bit est);
    @(negedge clk);
    enable = en; tick = tk; tone = est;
    model_step(en, tk, est);
    @(posedge clk);
    #1;
    check();
  endtask

  task automatic ticks(input int n, input bit est);
    for (int i = 0; i < n; i++) begin
      cyc(1, 1, est);
      cyc(1, 0, !est); // between-tick toggles must be ignored (R6)
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 0; enable = 0; tick = 0; tone = 0;
    pg = 4; ag = 3; mn = 2; mx = 50; gp = 10;
    model_clear(); m_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1"; check();
    @(negedge clk); rst_n = 1;
    cyc(0, 1, 1); cyc(0, 1, 1);

    cur_req = "R6";
    for (int i = 0; i < 6; i++) cyc(1, 0, i[0]);

    cur_req = "R2"; ticks(4, 1);
    cur_req = "R5"; ticks(5, 1);
    cur_req = "R7"; ticks(3, 0);   // release with strobe, length 8
    cur_req = "R4"; ticks(2, 0);

    cur_req = "R3";                // 1,2,1,2,3,4 -> qualifies on 6th tick
    ticks(2, 1); ticks(1, 0); ticks(3, 1);
    ticks(3, 0);

    cur_req = "R8"; mx = 5;
    ticks(4, 1); ticks(10, 1); ticks(3, 0);
    mx = 50;

    cur_req = "R9"; gp = 1; ag = 4;
    ticks(4, 1); ticks(2, 0); ticks(2, 1); ticks(4, 0);   // gap 2 > 1: no strobe
    ticks(4, 1); ticks(1, 0); ticks(2, 1); ticks(4, 0);   // gap 1: strobe

    cur_req = "R10";
    ticks(4, 1); cyc(0, 1, 1); cyc(1, 0, 1);
    ticks(3, 1); ticks(1, 1);
    ticks(4, 0);

    cur_req = "random";
    for (int seg = 0; seg < 8; seg++) begin
      cyc(0, 0, 0);
      pg = $urandom_range(0, 6); ag = $urandom_range(0, 6);
      mn = $urandom_range(0, 12); mx = $urandom_range(4, 40);
      gp = $urandom_range(0, 3);
      if (seg == 7) mx = SAT;
      cyc(0, 0, 0);
      begin
        bit est;
        est = 0;
        for (int i = 0; i < 2000; i++) begin
          if ($urandom_range(0, 99) < 12) est = !est;
          cyc(1, ($urandom_range(0, 2) == 0), est);
        end
      end
    end

    cur_req = "R7";
    n_vec++;
    if (n_strobe == 0) begin
      n_bad++;
      $display("FAIL R7: strobes seen=%0d expected >0", n_strobe);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule